// File: doc/BRIEF.md
# Safety Mode Manager with Suspect State

This controller steps a single-channel safety unit through its operating modes. Out of reset it sits in a startup mode and waits for three self-test engines to report success. It then enters normal or configuration operation, as chosen by a mode request. While the unit runs, on-line checkers raise error flags. A supervised acknowledgement that arrives too late also counts as an error.

A detected error does not stop the unit at once. The first error moves the controller into a suspect mode, where it asks for a restart. If an error shows up again before the suspect record has been cleared, the fault is treated as permanent. The controller then enters a latched safe mode that holds the actuators disabled until power-on reset. A clean startup followed by a full supervision window in normal mode clears the suspect record.

Top module: `smm_top`

## Requirements
- R1: During and right after reset, `mode_o` reads startup (code 0), and both `restart_req_o` and `safe_o` are low. The mode codes are: startup 0, normal 1, configuration 2, suspect 3, safe 4.
- R2: The unit leaves startup only after a pass pulse has been seen on each bit of `st_pass_i`. Bit 0 is the processor watchdog test, bit 1 the memory march test, and bit 2 the code-memory integrity check. The pulses may arrive in any order. The new mode appears one cycle after the cycle in which the last missing pass is captured. It is configuration if `cfg_req_i` is high in that cycle, and normal otherwise.
- R3: In startup, a high bit on `st_fail_i` is a detected error. In startup, `rt_err_i` has no effect.
- R4: In normal or configuration mode, `rt_err_i` high is a detected error. On the next clock the mode becomes suspect if no suspect record is held, and safe if one is held. The same rule applies to self-test failures in startup.
- R5: After `ack_req_i` is sampled in normal or configuration mode, the unit waits ACK_LIMIT cycles for `ack_seen_i`. If `ack_seen_i` is high in any of those cycles, no error results. If it never is, the last of those cycles counts as a detected error.
- R6: In suspect mode, `restart_req_o` is high and every error input is ignored. The mode stays suspect until `restart_done_i` is sampled high; the next mode is then startup. Self-test passes collected before the restart do not count afterwards.
- R7: Safe mode drives `safe_o` high and `restart_req_o` low. No input other than `rst_n` can leave safe mode.
- R8: A change between normal and configuration follows `cfg_req_i` (1 selects configuration) only in a cycle with no detected error. When both happen in the same cycle, the error decides the next mode.
- R9: The suspect record clears after WIN_CYCLES consecutive error-free cycles in normal mode. Any cycle spent in configuration mode restarts that count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| st_pass_i | input | N_TESTS | Self-test pass pulses, one bit per test |
| st_fail_i | input | N_TESTS | Self-test failure flags, one bit per test |
| rt_err_i | input | 1 | Error flag from on-line checkers |
| ack_req_i | input | 1 | Starts supervision of an expected acknowledgement |
| ack_seen_i | input | 1 | The expected acknowledgement has arrived |
| cfg_req_i | input | 1 | Mode request: 1 selects configuration, 0 selects normal |
| restart_done_i | input | 1 | The requested restart has completed |
| mode_o | output | 3 | Current operating mode code |
| restart_req_o | output | 1 | Restart request, high in suspect mode |
| safe_o | output | 1 | Actuator disable, high in safe mode |

## Verification
The hardest situation to create from the ports is a held suspect record meeting a second error exactly at the edge of the supervision window. The window is only one cycle too short in that case, or it was restarted by a short stay in configuration mode. The stimulus reaches this state through a real error, a restart and a complete self-test sequence. It then counts whole cycles spent in normal mode and injects the second error on the last cycle of the window. The bench also sweeps all six orders of the self-test passes. It alternates runtime errors with acknowledgement timeouts, and each round is closed by a full window, so every round also shows that the record was cleared.

// File: rtl/smm_pkg.sv
package smm_pkg;
  typedef enum logic [2:0] {
    MODE_STARTUP = 3'd0,
    MODE_NORMAL  = 3'd1,
    MODE_CONFIG  = 3'd2,
    MODE_SUSPECT = 3'd3,
    MODE_SAFE    = 3'd4
  } mode_e;
endpackage

// File: rtl/smm_selftest_gather.sv
// Sticky record of self-test passes; cleared whenever startup is not active.
module smm_selftest_gather #(
  parameter int N_TESTS = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr_i,
  input  logic [N_TESTS-1:0] pass_i,
  input  logic [N_TESTS-1:0] fail_i,
  output logic               all_pass_o,
  output logic               any_fail_o
);
  logic [N_TESTS-1:0] seen_q;
  logic [N_TESTS-1:0] seen_d;

  always_comb begin
    if (clr_i) seen_d = '0;
    else       seen_d = seen_q | pass_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_q <= '0;
    else        seen_q <= seen_d;
  end

  assign all_pass_o = &seen_q;
  assign any_fail_o = |fail_i;
endmodule

// File: rtl/smm_ack_timer.sv
// Acknowledgement supervision: timeout on the LIMIT-th cycle after the request.
module smm_ack_timer #(
  parameter int LIMIT = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active_i,
  input  logic req_i,
  input  logic ack_i,
  output logic timeout_o
);
  localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic          armed_q, armed_d;
  logic [CW-1:0] cnt_q, cnt_d;

  assign timeout_o = active_i && armed_q && !ack_i && (cnt_q == LAST);

  always_comb begin
    armed_d = armed_q;
    cnt_d   = cnt_q;
    if (!active_i) begin
      armed_d = 1'b0;
      cnt_d   = '0;
    end else if (req_i) begin
      armed_d = 1'b1;
      cnt_d   = '0;
    end else if (armed_q && (ack_i || timeout_o)) begin
      armed_d = 1'b0;
      cnt_d   = '0;
    end else if (armed_q) begin
      cnt_d   = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else begin
      armed_q <= armed_d;
      cnt_q   <= cnt_d;
    end
  end
endmodule

// File: rtl/smm_window.sv
// Counts consecutive clean supervised cycles; done on the WIN-th one.
module smm_window #(
  parameter int WIN = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic hit_i,
  output logic done_o
);
  localparam int CW = (WIN > 1) ? $clog2(WIN) : 1;
  localparam logic [CW-1:0] LAST = CW'(WIN - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  assign done_o = run_i && !hit_i && (cnt_q == LAST);

  always_comb begin
    if (!run_i || hit_i || done_o) cnt_d = '0;
    else                           cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/smm_top.sv
module smm_top
  import smm_pkg::*;
#(
  parameter int N_TESTS    = 3,
  parameter int ACK_LIMIT  = 8,
  parameter int WIN_CYCLES = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_TESTS-1:0] st_pass_i,
  input  logic [N_TESTS-1:0] st_fail_i,
  input  logic               rt_err_i,
  input  logic               ack_req_i,
  input  logic               ack_seen_i,
  input  logic               cfg_req_i,
  input  logic               restart_done_i,
  output logic [2:0]         mode_o,
  output logic               restart_req_o,
  output logic               safe_o
);
  mode_e mode_q, mode_d;
  logic  rec_q, rec_d;
  logic  all_pass, any_fail, ack_timeout, win_done;
  logic  running, err_now;

  assign running = (mode_q == MODE_NORMAL) || (mode_q == MODE_CONFIG);

  smm_selftest_gather #(.N_TESTS(N_TESTS)) u_gather (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr_i      (mode_q != MODE_STARTUP),
    .pass_i     (st_pass_i),
    .fail_i     (st_fail_i),
    .all_pass_o (all_pass),
    .any_fail_o (any_fail)
  );

  smm_ack_timer #(.LIMIT(ACK_LIMIT)) u_ack (
    .clk       (clk),
    .rst_n     (rst_n),
    .active_i  (running),
    .req_i     (ack_req_i),
    .ack_i     (ack_seen_i),
    .timeout_o (ack_timeout)
  );

  always_comb begin
    case (mode_q)
      MODE_STARTUP:            err_now = any_fail;
      MODE_NORMAL, MODE_CONFIG: err_now = rt_err_i || ack_timeout;
      default:                 err_now = 1'b0;
    endcase
  end

  smm_window #(.WIN(WIN_CYCLES)) u_win (
    .clk    (clk),
    .rst_n  (rst_n),
    .run_i  ((mode_q == MODE_NORMAL) && rec_q),
    .hit_i  (err_now),
    .done_o (win_done)
  );

  // next-state logic
  always_comb begin
    mode_d = mode_q;
    if (err_now) begin
      mode_d = rec_q ? MODE_SAFE : MODE_SUSPECT;
    end else begin
      case (mode_q)
        MODE_STARTUP: if (all_pass) mode_d = cfg_req_i ? MODE_CONFIG : MODE_NORMAL;
        MODE_NORMAL:  if (cfg_req_i) mode_d = MODE_CONFIG;
        MODE_CONFIG:  if (!cfg_req_i) mode_d = MODE_NORMAL;
        MODE_SUSPECT: if (restart_done_i) mode_d = MODE_STARTUP;
        default:      mode_d = MODE_SAFE;
      endcase
    end
  end

  always_comb begin
    rec_d = rec_q;
    if (err_now)       rec_d = 1'b1;
    else if (win_done) rec_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_STARTUP;
      rec_q  <= 1'b0;
    end else begin
      mode_q <= mode_d;
      rec_q  <= rec_d;
    end
  end

  assign mode_o        = mode_q;
  assign restart_req_o = (mode_q == MODE_SUSPECT);
  assign safe_o        = (mode_q == MODE_SAFE);
endmodule

// File: rtl/smm_top_chk.sv
module smm_top_chk
  import smm_pkg::*;
#(
  parameter int N_TESTS = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic [N_TESTS-1:0] st_fail_i,
  input logic               rt_err_i,
  input logic               restart_done_i,
  input logic [2:0]         mode_o,
  input logic               restart_req_o,
  input logic               safe_o
);
  a_r7_safe_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == MODE_SAFE) |=> (mode_o == MODE_SAFE));

  a_r7_safe_outputs: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == MODE_SAFE) |-> (safe_o && !restart_req_o));

  a_r6_suspect_wait: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == MODE_SUSPECT && !restart_done_i) |=> (mode_o == MODE_SUSPECT));

  a_r6_suspect_release: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == MODE_SUSPECT && restart_done_i) |=> (mode_o == MODE_STARTUP));

  a_r4_error_exits: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_o == MODE_NORMAL || mode_o == MODE_CONFIG) && rt_err_i)
      |=> (mode_o == MODE_SUSPECT || mode_o == MODE_SAFE));

  a_r3_fail_exits: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == MODE_STARTUP && (|st_fail_i))
      |=> (mode_o == MODE_SUSPECT || mode_o == MODE_SAFE));
endmodule

bind smm_top smm_top_chk #(.N_TESTS(N_TESTS)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .st_fail_i      (st_fail_i),
  .rt_err_i       (rt_err_i),
  .restart_done_i (restart_done_i),
  .mode_o         (mode_o),
  .restart_req_o  (restart_req_o),
  .safe_o         (safe_o)
);

// File: tb/smm_top_bench.sv
`timescale 1ns/1ps
module smm_top_bench;
  import smm_pkg::*;
  localparam int NT  = 3;
  localparam int ACK = 8;
  localparam int WIN = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [NT-1:0] st_pass_i, st_fail_i;
  logic          rt_err_i, ack_req_i, ack_seen_i, cfg_req_i, restart_done_i;
  logic [2:0]    mode_o;
  logic          restart_req_o, safe_o;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  smm_top #(.N_TESTS(NT), .ACK_LIMIT(ACK), .WIN_CYCLES(WIN)) u_smm_top (
    .clk(clk), .rst_n(rst_n), .st_pass_i(st_pass_i), .st_fail_i(st_fail_i),
    .rt_err_i(rt_err_i), .ack_req_i(ack_req_i), .ack_seen_i(ack_seen_i),
    .cfg_req_i(cfg_req_i), .restart_done_i(restart_done_i),
    .mode_o(mode_o), .restart_req_o(restart_req_o), .safe_o(safe_o)
  );

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(string req, mode_e exp);
    logic exp_rr, exp_safe;
    exp_rr   = (exp == MODE_SUSPECT);
    exp_safe = (exp == MODE_SAFE);
    checks++;
    if (mode_o !== 3'(exp) || restart_req_o !== exp_rr || safe_o !== exp_safe) begin
      errors++;
      $display("FAIL %s: mode=%0d rr=%0b safe=%0b expected mode=%0d rr=%0b safe=%0b",
               req, mode_o, restart_req_o, safe_o, exp, exp_rr, exp_safe);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    st_pass_i = '0; st_fail_i = '0; rt_err_i = 0; ack_req_i = 0;
    ack_seen_i = 0; cfg_req_i = 0; restart_done_i = 0;
    step(); step();
    chk("R1 in reset", MODE_STARTUP);
    rst_n = 1'b1;
    step();
    chk("R1 after reset", MODE_STARTUP);
  endtask

  // perm index selects one of the six pass orders
  task automatic bring_up(int p, logic cfg);
    int ord[3];
    case (p)
      0: ord = '{0, 1, 2};
      1: ord = '{0, 2, 1};
      2: ord = '{1, 0, 2};
      3: ord = '{1, 2, 0};
      4: ord = '{2, 0, 1};
      default: ord = '{2, 1, 0};
    endcase
    cfg_req_i = cfg;
    for (int i = 0; i < 3; i++) begin
      st_pass_i = NT'(1) << ord[i];
      step();
      st_pass_i = '0;
      chk("R2 still startup", MODE_STARTUP);
    end
    step();
    chk("R2 leave startup", cfg ? MODE_CONFIG : MODE_NORMAL);
  endtask

  task automatic restart_seq();
    rt_err_i = 1; st_fail_i = '1;
    step(); chk("R6 hold suspect", MODE_SUSPECT);
    step(); chk("R6 errors ignored", MODE_SUSPECT);
    rt_err_i = 0; st_fail_i = '0;
    restart_done_i = 1;
    step();
    restart_done_i = 0;
    chk("R6 back to startup", MODE_STARTUP);
  endtask

  initial begin
    #(4 * 190000);
    errors++; checks++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    do_reset();

    // sweep all pass orders; alternate error sources; window clears record (R9)
    for (int k = 0; k < 6; k++) begin
      bring_up(k, k[0]);
      if (k[0]) begin
        cfg_req_i = 0;
        step();
        chk("R8 config to normal", MODE_NORMAL);
      end
      repeat (WIN) step();
      chk("R9 clean window", MODE_NORMAL);
      if (!k[0]) begin
        rt_err_i = 1; step(); rt_err_i = 0;
        chk("R4/R9 runtime error goes suspect", MODE_SUSPECT);
      end else begin
        ack_req_i = 1; step(); ack_req_i = 0;
        repeat (ACK - 1) step();
        chk("R5 before timeout", MODE_NORMAL);
        step();
        chk("R5 ack timeout", MODE_SUSPECT);
      end
      restart_seq();
    end

    // late but valid acknowledgement, record held then cleared
    bring_up(0, 1'b0);
    ack_req_i = 1; step(); ack_req_i = 0;
    repeat (ACK - 1) step();
    ack_seen_i = 1; step(); ack_seen_i = 0;
    chk("R5 ack on last cycle", MODE_NORMAL);
    repeat (ACK + 2) step();
    chk("R5 timer disarmed", MODE_NORMAL);
    repeat (WIN) step();

    // error beats mode request
    cfg_req_i = 1; rt_err_i = 1; step(); rt_err_i = 0; cfg_req_i = 0;
    chk("R8 error wins over request", MODE_SUSPECT);
    restart_seq();

    // self-test failure with record held: permanent
    st_fail_i = 3'b010; step(); st_fail_i = '0;
    chk("R4 repeat error to safe", MODE_SAFE);
    restart_done_i = 1; rt_err_i = 1; st_pass_i = '1; cfg_req_i = 1;
    repeat (5) step();
    chk("R7 safe latched", MODE_SAFE);
    restart_done_i = 0; rt_err_i = 0; st_pass_i = '0; cfg_req_i = 0;
    step();
    chk("R7 still safe", MODE_SAFE);

    do_reset();
    rt_err_i = 1; repeat (3) step(); rt_err_i = 0;
    chk("R3 runtime error ignored in startup", MODE_STARTUP);
    st_pass_i = 3'b011; step(); st_pass_i = '0;
    st_fail_i = 3'b100; step(); st_fail_i = '0;
    chk("R3 self-test failure to suspect", MODE_SUSPECT);
    restart_seq();
    st_pass_i = 3'b100; step(); st_pass_i = '0;
    repeat (3) step();
    chk("R6 earlier passes discarded", MODE_STARTUP);
    st_pass_i = 3'b011; step(); st_pass_i = '0;
    step();
    chk("R2 leave after remaining passes", MODE_NORMAL);

    // window restarted by a configuration cycle
    repeat (WIN - 2) step();
    cfg_req_i = 1; step(); chk("R8 normal to config", MODE_CONFIG);
    cfg_req_i = 0; step(); chk("R8 back to normal", MODE_NORMAL);
    repeat (WIN - 2) step();
    rt_err_i = 1; step(); rt_err_i = 0;
    chk("R9 window restarted, error is permanent", MODE_SAFE);

    do_reset();
    bring_up(3, 1'b0);
    rt_err_i = 1; step(); rt_err_i = 0;
    chk("R4 first error after reset", MODE_SUSPECT);
    restart_seq();
    bring_up(5, 1'b0);
    repeat (WIN - 1) step();
    rt_err_i = 1; step(); rt_err_i = 0;
    chk("R9 window one short", MODE_SAFE);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule